// File: doc/BRIEF.md
# Self-Loop Attack Test Controller

This controller runs a self-loop attack test on a column-organised array of eight-transistor memory cells. Each cell has one shared read-write word line, two column write word lines (one per storage node), a single bit line and a switchable source level on its read path. During the attack both column write word lines are raised together while the row word line stays low and the bit line is left undriven. Every cell in the column then has its two storage nodes fighting through its own pass gates, and each cell settles to a final state. The array model produces that final state. A defective cell settles to a state that differs from a healthy one.

The controller takes a 2-bit mode that selects one of four configurations. A configuration fixes the initial target data, the initial background data, the source level and the expected final states. For each configuration the controller sets the array to its initial state, fires the column pulses and reads each column back as one operation. It compares every row against the expected value and records the first failure: the lowest mismatching row of the earliest failing read, the column of that read, and the configuration number.

Top module: `slat_ctrl`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` rises on the next cycle and stays high up to and including the single `done` cycle. `start` asserted while `busy` is high has no effect. Whenever `busy` is low, `arr_cmd` is 0 (no operation).
- R2: Command codes on `arr_cmd` are: 0 none, 1 single-cell write, 2 whole-column write, 3 attack pulse, 4 column read. During an attack pulse, `arr_wl` is 0, `arr_wwla` and `arr_wwlb` are both 1, and `arr_bl_drive` is 0.
- R3: During a column read, `arr_wl` is 1 and both column write word lines are 0. Each column is read only after that column has been pulsed in the same run.
- R4: Both write kinds (codes 1 and 2) drive `arr_wl` and pull the bit line low (`arr_bl_drive`=1). Exactly one column write word line is raised: `arr_wwla` when writing 1, `arr_wwlb` when writing 0.
- R5: The modes map as follows. Mode 0 is configuration 1 (target 0, background 0, source 0) in batch order. Mode 1 is configuration 5 (1, 0, 0) run target by target. Mode 2 is configuration 8 (1, 1, 1) interleaved per column. Mode 3 is configuration 1 interleaved per column. `fail_cfg` reports 1, 5, 8 or 1, and `arr_vvss` carries the source level while `busy` is high.
- R6: Mode 0 issues ROWS*COLS single writes of 0, then one pulse per column, then one column read per column. All pulses come before the first read.
- R7: Mode 1 does the following for every cell, column by column with rows ascending: a column write of 0, a single write of 1 to the target row, a pulse, and a column read. That is ROWS*COLS operations of each kind.
- R8: Modes 2 and 3 write every cell with the initial value, then for each column issue a pulse immediately followed by that column's read.
- R9: The expected final value is 1 on every row for configurations 1 and 8. For configuration 5 it is 0 on the target row and 1 on every other row.
- R10: On the first mismatching read, `fail` sets and `fail_row`/`fail_col` capture the lowest mismatching row and its column. Later mismatches do not change them. An accepted `start` clears them.
- R11: After reset, `busy`, `done`, `fail`, `fail_row`, `fail_col`, `fail_cfg` and `arr_cmd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (accepted when idle) |
| mode | input | 2 | Configuration select |
| arr_cmd | output | 3 | Array operation code |
| arr_row | output | RW | Row for single-cell writes |
| arr_col | output | CW | Column for every operation |
| arr_wl | output | 1 | Read-write word line enable |
| arr_wwla | output | 1 | Column write word line toward the 1 side |
| arr_wwlb | output | 1 | Column write word line toward the 0 side |
| arr_bl_drive | output | 1 | Bit line driven low |
| arr_vvss | output | 1 | Read-path source level |
| rd_valid | input | 1 | Column read data valid |
| rd_data | input | ROWS | All row values of the read column |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| fail | output | 1 | Sticky mismatch flag |
| fail_row | output | RW | Lowest mismatching row of first failing read |
| fail_col | output | CW | Column of first failing read |
| fail_cfg | output | 4 | Configuration number of the run |

## Verification
Each mode is first run on a defect-free array to confirm the operation counts, ordering and signal levels per configuration. It is then run with cells forced to a stuck final state. Stuck-at-0 cells separate the all-ones configurations from the per-target one, and stuck-at-1 cells are caught only when the target row is expected to fall to 0. Several defects in one column, and defects in different columns, show that the report picks the lowest row of the earliest failing read. A start pulse issued mid-run with a different mode, and a clean run after a failing one, show that the configuration is held and that the failure record is cleared.

// File: rtl/slat_pkg.sv
package slat_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_WR    = 3'd1,
    CMD_COLWR = 3'd2,
    CMD_PULSE = 3'd3,
    CMD_COLRD = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    FLOW_BATCH  = 2'd0,
    FLOW_INTER  = 2'd1,
    FLOW_TARGET = 2'd2
  } flow_e;

  typedef struct packed {
    logic       init_tg;
    logic       init_bg;
    logic       vvss;
    logic       fin_tg;
    logic       fin_bg;
    flow_e      flow;
    logic [3:0] num;
  } cfg_t;

  function automatic cfg_t cfg_of(input logic [1:0] mode);
    cfg_t c;
    case (mode)
      2'd0:    c = '{init_tg:1'b0, init_bg:1'b0, vvss:1'b0, fin_tg:1'b1, fin_bg:1'b1,
                     flow:FLOW_BATCH, num:4'd1};
      2'd1:    c = '{init_tg:1'b1, init_bg:1'b0, vvss:1'b0, fin_tg:1'b0, fin_bg:1'b1,
                     flow:FLOW_TARGET, num:4'd5};
      2'd2:    c = '{init_tg:1'b1, init_bg:1'b1, vvss:1'b1, fin_tg:1'b1, fin_bg:1'b1,
                     flow:FLOW_INTER, num:4'd8};
      default: c = '{init_tg:1'b0, init_bg:1'b0, vvss:1'b0, fin_tg:1'b1, fin_bg:1'b1,
                     flow:FLOW_INTER, num:4'd1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/slat_seq.sv
module slat_seq
  import slat_pkg::*;
#(
  parameter  int ROWS = 16,
  parameter  int COLS = 4,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          rd_valid,
  output cmd_e          cmd,
  output logic          wdata,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output cfg_t          cfg,
  output logic          busy,
  output logic          done,
  output logic          start_acc,
  output logic          cmp_en
);

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_CLR, S_TGT, S_PULSE, S_READ, S_WAIT, S_DONE
  } state_e;

  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  state_e        state_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  cfg_t          cfg_q;
  cfg_t          cfg_new;
  logic          last_row;
  logic          last_col;

  assign cfg_new   = cfg_of(mode);
  assign last_row  = (row_q == ROW_LAST);
  assign last_col  = (col_q == COL_LAST);
  assign start_acc = (state_q == S_IDLE) && start;
  assign cmp_en    = (state_q == S_WAIT) && rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      cfg_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          cfg_q   <= cfg_new;
          row_q   <= '0;
          col_q   <= '0;
          state_q <= (cfg_new.flow == FLOW_TARGET) ? S_CLR : S_INIT;
        end
        S_INIT: begin
          if (last_row) begin
            row_q <= '0;
            if (last_col) begin
              col_q   <= '0;
              state_q <= S_PULSE;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        S_CLR:   state_q <= S_TGT;
        S_TGT:   state_q <= S_PULSE;
        S_PULSE: begin
          if (cfg_q.flow == FLOW_BATCH) begin
            if (last_col) begin
              col_q   <= '0;
              state_q <= S_READ;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end else begin
            state_q <= S_READ;
          end
        end
        S_READ:  state_q <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          case (cfg_q.flow)
            FLOW_BATCH: begin
              if (last_col) state_q <= S_DONE;
              else begin
                col_q   <= col_q + 1'b1;
                state_q <= S_READ;
              end
            end
            FLOW_TARGET: begin
              if (last_row) begin
                row_q <= '0;
                if (last_col) state_q <= S_DONE;
                else begin
                  col_q   <= col_q + 1'b1;
                  state_q <= S_CLR;
                end
              end else begin
                row_q   <= row_q + 1'b1;
                state_q <= S_CLR;
              end
            end
            default: begin
              if (last_col) state_q <= S_DONE;
              else begin
                col_q   <= col_q + 1'b1;
                state_q <= S_PULSE;
              end
            end
          endcase
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd   = CMD_NOP;
    wdata = 1'b0;
    case (state_q)
      S_INIT:  begin cmd = CMD_WR;    wdata = cfg_q.init_tg; end
      S_CLR:   begin cmd = CMD_COLWR; wdata = cfg_q.init_bg; end
      S_TGT:   begin cmd = CMD_WR;    wdata = cfg_q.init_tg; end
      S_PULSE: cmd = CMD_PULSE;
      S_READ:  cmd = CMD_COLRD;
      default: cmd = CMD_NOP;
    endcase
  end

  assign row  = row_q;
  assign col  = col_q;
  assign cfg  = cfg_q;
  assign busy = (state_q != S_IDLE);
  assign done = (state_q == S_DONE);

endmodule

// File: rtl/slat_cmp.sv
module slat_cmp #(
  parameter  int ROWS = 16,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0] rd_data,
  input  logic            fin_tg,
  input  logic            fin_bg,
  input  logic            per_target,
  input  logic [RW-1:0]   tgt_row,
  output logic [ROWS-1:0] exp_vec,
  output logic            mismatch,
  output logic [RW-1:0]   low_row
);

  function automatic logic [ROWS-1:0] expect_vec(input logic ft, input logic fb,
                                                 input logic pt, input logic [RW-1:0] t);
    logic [ROWS-1:0] v;
    for (int i = 0; i < ROWS; i++)
      v[i] = (pt && (RW'(i) == t)) ? ft : fb;
    return v;
  endfunction

  function automatic logic [RW-1:0] lowest_set(input logic [ROWS-1:0] v);
    logic [RW-1:0] r;
    r = '0;
    for (int i = ROWS - 1; i >= 0; i--)
      if (v[i]) r = RW'(i);
    return r;
  endfunction

  logic [ROWS-1:0] diff;

  assign exp_vec  = expect_vec(fin_tg, fin_bg, per_target, tgt_row);
  assign diff     = rd_data ^ exp_vec;
  assign mismatch = |diff;
  assign low_row  = lowest_set(diff);

endmodule

// File: rtl/slat_log.sv
module slat_log #(
  parameter  int ROWS = 16,
  parameter  int COLS = 4,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cmp_en,
  input  logic          mismatch,
  input  logic [RW-1:0] low_row,
  input  logic [CW-1:0] col,
  output logic          fail,
  output logic [RW-1:0] fail_row,
  output logic [CW-1:0] fail_col
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= 1'b0;
      fail_row <= '0;
      fail_col <= '0;
    end else if (clr) begin
      fail     <= 1'b0;
      fail_row <= '0;
      fail_col <= '0;
    end else if (cmp_en && mismatch && !fail) begin
      fail     <= 1'b1;
      fail_row <= low_row;
      fail_col <= col;
    end
  end

endmodule

// File: rtl/slat_ctrl.sv
module slat_ctrl
  import slat_pkg::*;
#(
  parameter  int ROWS = 16,
  parameter  int COLS = 4,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  output logic [2:0]      arr_cmd,
  output logic [RW-1:0]   arr_row,
  output logic [CW-1:0]   arr_col,
  output logic            arr_wl,
  output logic            arr_wwla,
  output logic            arr_wwlb,
  output logic            arr_bl_drive,
  output logic            arr_vvss,
  input  logic            rd_valid,
  input  logic [ROWS-1:0] rd_data,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [RW-1:0]   fail_row,
  output logic [CW-1:0]   fail_col,
  output logic [3:0]      fail_cfg
);

  cmd_e            cmd;
  logic            wdata;
  cfg_t            cfg;
  logic            start_acc;
  logic            ev_cmp;
  logic            ev_mismatch;
  logic [RW-1:0]   ev_low_row;
  logic [ROWS-1:0] ev_exp_vec;
  logic            is_write;

  slat_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rd_valid(rd_valid),
    .cmd(cmd), .wdata(wdata), .row(arr_row), .col(arr_col), .cfg(cfg),
    .busy(busy), .done(done), .start_acc(start_acc), .cmp_en(ev_cmp)
  );

  slat_cmp #(.ROWS(ROWS)) u_cmp (
    .rd_data(rd_data), .fin_tg(cfg.fin_tg), .fin_bg(cfg.fin_bg),
    .per_target(cfg.flow == FLOW_TARGET), .tgt_row(arr_row),
    .exp_vec(ev_exp_vec), .mismatch(ev_mismatch), .low_row(ev_low_row)
  );

  slat_log #(.ROWS(ROWS), .COLS(COLS)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .cmp_en(ev_cmp),
    .mismatch(ev_mismatch), .low_row(ev_low_row), .col(arr_col),
    .fail(fail), .fail_row(fail_row), .fail_col(fail_col)
  );

  assign is_write     = (cmd == CMD_WR) || (cmd == CMD_COLWR);
  assign arr_cmd      = cmd;
  assign arr_wl       = is_write || (cmd == CMD_COLRD);
  assign arr_wwla     = (is_write && wdata)  || (cmd == CMD_PULSE);
  assign arr_wwlb     = (is_write && !wdata) || (cmd == CMD_PULSE);
  assign arr_bl_drive = is_write;
  assign arr_vvss     = busy && cfg.vvss;
  assign fail_cfg     = cfg.num;

endmodule

// File: rtl/slat_ctrl_chk.sv
module slat_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic [2:0] arr_cmd,
  input logic       arr_wl,
  input logic       arr_wwla,
  input logic       arr_wwlb,
  input logic       arr_bl_drive,
  input logic       cmp_en,
  input logic       mismatch
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> arr_cmd == 3'd0); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R1
  AST_PULSE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cmd == 3'd3 |-> (!arr_wl && arr_wwla && arr_wwlb && !arr_bl_drive)); // R2
  AST_READ_WWL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cmd == 3'd4 |-> (arr_wl && !arr_wwla && !arr_wwlb)); // R3
  AST_WRITE_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cmd == 3'd1 || arr_cmd == 3'd2) |-> (arr_wl && arr_bl_drive && $onehot({arr_wwla, arr_wwlb}))); // R4
  AST_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && mismatch) |=> fail); // R10
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail); // R10

endmodule

bind slat_ctrl slat_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .arr_cmd(arr_cmd), .arr_wl(arr_wl), .arr_wwla(arr_wwla), .arr_wwlb(arr_wwlb),
  .arr_bl_drive(arr_bl_drive), .cmp_en(ev_cmp), .mismatch(ev_mismatch)
);

// File: tb/slat_ctrl_test.sv
module slat_ctrl_test;

  localparam int ROWS = 16;
  localparam int COLS = 4;
  localparam int RW   = 4;
  localparam int CW   = 2;
  localparam int N    = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic [2:0]      arr_cmd;
  logic [RW-1:0]   arr_row;
  logic [CW-1:0]   arr_col;
  logic            arr_wl, arr_wwla, arr_wwlb, arr_bl_drive, arr_vvss;
  logic            rd_valid = 1'b0;
  logic [ROWS-1:0] rd_data = '0;
  logic            busy, done, fail;
  logic [RW-1:0]   fail_row;
  logic [CW-1:0]   fail_col;
  logic [3:0]      fail_cfg;

  always #2.5 clk = ~clk;

  slat_ctrl #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .arr_cmd(arr_cmd), .arr_row(arr_row), .arr_col(arr_col), .arr_wl(arr_wl),
    .arr_wwla(arr_wwla), .arr_wwlb(arr_wwlb), .arr_bl_drive(arr_bl_drive),
    .arr_vvss(arr_vvss), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .fail(fail), .fail_row(fail_row),
    .fail_col(fail_col), .fail_cfg(fail_cfg)
  );

  // Behavioural array: a column pulse leaves a lone 1 at 0 and the rest at 1,
  // any other column pattern settles to all ones; defective cells settle stuck.
  bit mem   [COLS][ROWS];
  bit dmask [COLS][ROWS];
  bit dval  [COLS][ROWS];
  int ones;
  bit nv;

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    case (arr_cmd)
      3'd1: mem[arr_col][arr_row] <= arr_wwla;
      3'd2: for (int r = 0; r < ROWS; r++) mem[arr_col][r] <= arr_wwla;
      3'd3: begin
        ones = 0;
        for (int r = 0; r < ROWS; r++) ones += int'(mem[arr_col][r]);
        for (int r = 0; r < ROWS; r++) begin
          nv = (ones == 1) ? !mem[arr_col][r] : 1'b1;
          if (dmask[arr_col][r]) nv = dval[arr_col][r];
          mem[arr_col][r] <= nv;
        end
      end
      3'd4: begin
        for (int r = 0; r < ROWS; r++) rd_data[r] <= mem[arr_col][r];
        rd_valid <= 1'b1;
      end
      default: ;
    endcase
  end

  typedef struct {
    int mode; bit f; int fr; int fc; int cfg;
    int wr; int colwr; int pulse; int rd; int first; bit vv;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_defects();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) begin dmask[c][r] = 0; dval[c][r] = 0; end
  endtask

  task automatic set_defect(input int r, input int c, input bit v);
    dmask[c][r] = 1; dval[c][r] = v;
  endtask

  // R9/R10 restated: walk reads in issue order, rows ascending within each read.
  task automatic expect_fail(input int m, output bit f, output int fr, output int fc);
    int targets;
    bit e, a;
    f = 0; fr = 0; fc = 0;
    targets = (m == 1) ? ROWS : 1;
    for (int c = 0; c < COLS; c++)
      for (int t = 0; t < targets; t++)
        for (int r = 0; r < ROWS; r++) begin
          e = (m == 1) ? (r != t) : 1'b1;
          a = dmask[c][r] ? dval[c][r] : e;
          if (!f && a != e) begin f = 1; fr = r; fc = c; end
        end
  endtask

  task automatic run(input int m, input bit poke);
    item_t it;
    it.mode = m;
    expect_fail(m, it.f, it.fr, it.fc);
    case (m)
      0: begin it.cfg = 1; it.wr = N; it.colwr = 0; it.pulse = COLS; it.rd = COLS; it.first = COLS; it.vv = 0; end
      1: begin it.cfg = 5; it.wr = N; it.colwr = N; it.pulse = N; it.rd = N; it.first = 1; it.vv = 0; end
      2: begin it.cfg = 8; it.wr = N; it.colwr = 0; it.pulse = COLS; it.rd = COLS; it.first = 1; it.vv = 1; end
      default: begin it.cfg = 1; it.wr = N; it.colwr = 0; it.pulse = COLS; it.rd = COLS; it.first = 1; it.vv = 0; end
    endcase
    sb.push_back(it);
    @(negedge clk);
    mode = 2'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      mode = 2'(m) ^ 2'b01; start = 1'b1;   // R1: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: counts operations and levels, then compares at the done strobe.
  int n_wr = 0, n_colwr = 0, n_pulse = 0, n_rd = 0, first_rd = -1, bad_lvl = 0, bad_vv = 0;

  always @(negedge clk) begin
    if (rst_n && busy && sb.size() != 0) begin
      if (arr_vvss != sb[0].vv) bad_vv++;
      case (arr_cmd)
        3'd1: begin n_wr++;    if (!(arr_wl && arr_bl_drive && (arr_wwla ^ arr_wwlb))) bad_lvl++; end
        3'd2: begin n_colwr++; if (!(arr_wl && arr_bl_drive && arr_wwlb && !arr_wwla)) bad_lvl++; end
        3'd3: begin n_pulse++; if (arr_wl || !arr_wwla || !arr_wwlb || arr_bl_drive) bad_lvl++; end
        3'd4: begin
          if (first_rd < 0) first_rd = n_pulse;
          n_rd++;
          if (!arr_wl || arr_wwla || arr_wwlb) bad_lvl++;
        end
        default: ;
      endcase
      if (done) begin
        item_t it;
        it = sb.pop_front();
        chk(fail == it.f, $sformatf("R10 fail flag mode%0d", it.mode), fail, it.f);
        if (it.f) begin
          chk(fail_row == RW'(it.fr), $sformatf("R10 fail_row mode%0d", it.mode), fail_row, it.fr);
          chk(fail_col == CW'(it.fc), $sformatf("R10 fail_col mode%0d", it.mode), fail_col, it.fc);
        end
        chk(fail_cfg == 4'(it.cfg), $sformatf("R5 fail_cfg mode%0d", it.mode), fail_cfg, it.cfg);
        chk(bad_vv == 0, $sformatf("R5 vvss level mode%0d", it.mode), bad_vv, 0);
        chk(n_wr == it.wr, $sformatf("R6 R7 R8 write count mode%0d", it.mode), n_wr, it.wr);
        chk(n_colwr == it.colwr, $sformatf("R7 column write count mode%0d", it.mode), n_colwr, it.colwr);
        chk(n_pulse == it.pulse, $sformatf("R6 R7 R8 pulse count mode%0d", it.mode), n_pulse, it.pulse);
        chk(n_rd == it.rd, $sformatf("R6 R7 R8 read count mode%0d", it.mode), n_rd, it.rd);
        chk(first_rd == it.first, $sformatf("R3 R6 pulses before first read mode%0d", it.mode), first_rd, it.first);
        chk(bad_lvl == 0, $sformatf("R2 R3 R4 line levels mode%0d", it.mode), bad_lvl, 0);
        n_wr = 0; n_colwr = 0; n_pulse = 0; n_rd = 0; first_rd = -1; bad_lvl = 0; bad_vv = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_defects();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 0, "R11 busy", busy, 0);
    chk(done == 0, "R11 done", done, 0);
    chk(fail == 0, "R11 fail", fail, 0);
    chk(arr_cmd == 0, "R11 arr_cmd", arr_cmd, 0);
    chk(fail_cfg == 0, "R11 fail_cfg", fail_cfg, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && arr_cmd == 0, "R1 idle quiet", busy, 0);

    run(0, 0);                                            // R6 clean
    set_defect(9, 2, 0); set_defect(4, 2, 0); set_defect(1, 3, 0);
    run(0, 0);                                            // R10 lowest row of first failing read
    clear_defects(); set_defect(6, 1, 1);
    run(0, 0);                                            // R9 stuck-1 passes all-ones config
    clear_defects();
    run(1, 0);                                            // R7 clean
    set_defect(7, 1, 1);
    run(1, 0);                                            // R9 target expected 0
    clear_defects(); set_defect(0, 0, 0);
    run(1, 0);
    clear_defects();
    run(2, 1);                                            // R1 mid-run start ignored, R8
    set_defect(15, 3, 0);
    run(2, 0);
    clear_defects(); set_defect(3, 0, 0); set_defect(2, 1, 0);
    run(3, 0);                                            // R8 interleaved config 1
    clear_defects();
    run(3, 0);                                            // R10 cleared by new start
    repeat (3) @(negedge clk);
    chk(busy == 0 && arr_cmd == 0, "R1 idle after runs", busy, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule